// File: doc/BRIEF.md
# DMA Remaining-Byte Counter with Command Decoder

This block keeps the count of bytes still to be moved by a peripheral DMA engine. It also decodes the 8-bit command codes that start a transfer, stop one or return the unit to its reset state. Software builds a new count through a byte-lane register port, from the lowest lane upward. Lower lanes are held in a staging register. The working count changes only when a write reaches the top lane, and that write merges any lower lanes it carries in the same cycle.

While a transfer runs, each accepted data beat lowers the count by the number of bytes it carried. When the count runs out, the block drops `busy` and pulses `done`. In the generic mode, a configuration input can switch the counter off. The transfer then ignores the count, and an external end-of-transfer strobe finishes it when data flows from the device to the host. That strobe also raises a flush pulse, so the partly filled last packet gets released.

Top module: `dmaCountUnit`

## Requirements
- R1: A write whose byte-enable includes lane 3 (bits [31:24]) loads the working count `remainCnt` on the next clock edge. Lanes enabled in the same write take their new bytes, and the other lower lanes take their staged bytes.
- R2: A write that enables only lanes 0 to 2 updates the staged bytes and leaves `remainCnt` unchanged.
- R3: Both `rstN` low and `busReset` high clear `remainCnt` and all staged bytes to zero.
- R4: When idle, a command in 00h..07h starts a transfer and raises `busy`. Code bits [2:1] select the mode: 0 generic, 1 UDMA, 2 PIO, 3 MDMA. Bit 0 set means device-to-host.
- R5: While busy with the counter enabled, each beat lowers the count by `beatBytes`, with a floor of zero so it never wraps. The beat that brings the count to zero drops `busy` and raises `done` for exactly one cycle.
- R6: In PIO mode, each beat lowers the count by 2, whatever `beatBytes` is.
- R7: A start command while busy is ignored. A start with a zero count and the counter enabled gives a `done` pulse on the next cycle and leaves `busy` low.
- R8: Command 11h clears the count, the staged bytes and `busy`, and returns the unit to its reset state.
- R9: Command 12h ends a busy MDMA transfer without a `done` pulse. In any other mode, or when idle, it has no effect.
- R10: Command codes 13h..FFh and 08h..10h change nothing.
- R11: In generic mode with `cntDisable` high, beats do not change the count. `eotIn` ends a device-to-host transfer, with `done` and `eotFlush` pulsing together. In the other modes, `cntDisable` is ignored.
- R12: If a top-lane commit and a beat fall in the same cycle, the committed value wins and the beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| busReset | input | 1 | Synchronous bus reset, clears count bytes |
| wrEn | input | 1 | Register write strobe |
| wrByteEn | input | 4 | Byte-lane enables for the write |
| wrData | input | 32 | Write data, lane k in bits [8k+7:8k] |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command code |
| cntDisable | input | 1 | Counter disable, honoured in generic mode only |
| beatValid | input | 1 | One data beat moved this cycle |
| beatBytes | input | 3 | Bytes carried by the beat (1 to 4) |
| eotIn | input | 1 | External end-of-transfer strobe |
| remainCnt | output | 32 | Bytes still to transfer |
| busy | output | 1 | Transfer active |
| done | output | 1 | One-cycle completion pulse |
| eotFlush | output | 1 | One-cycle pulse to release the last partial packet |

## Verification
A software commit of a new count and a data beat can land on the same clock edge, and the two disagree about the next count. The bench drives a top-lane write and a 4-byte beat in one cycle during a running transfer. It then expects the written value, with no beat subtracted and `busy` still high. A second clash tested is a stop command during a non-MDMA transfer, which must leave the transfer running.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;

  typedef enum logic [1:0] {
    MODE_GDMA = 2'd0,
    MODE_UDMA = 2'd1,
    MODE_PIO  = 2'd2,
    MODE_MDMA = 2'd3
  } xferMode_e;

  localparam logic [7:0] CMD_LAST_START = 8'h07;
  localparam logic [7:0] CMD_UNIT_RESET = 8'h11;
  localparam logic [7:0] CMD_MDMA_STOP  = 8'h12;

  typedef struct packed {
    logic clearAll;
    logic decEn;
    logic stepTwo;
  } pathCtl_t;

endpackage

// File: rtl/dmaCountPath.sv
module dmaCountPath
  import dma_cnt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BEAT_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReset,
  input  logic                 wrEn,
  input  logic [CNT_W/8-1:0]   wrByteEn,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [BEAT_W-1:0]    beatBytes,
  input  pathCtl_t             ctl,
  output logic [CNT_W-1:0]     cnt,
  output logic                 cntIsZero,
  output logic                 lastBeat
);
  localparam int LANES = CNT_W / 8;

  logic [LANES-2:0][7:0] staged;
  logic [CNT_W-1:0]      mergedCnt;
  logic [CNT_W-1:0]      step;
  logic                  commit;
  logic                  wipe;

  assign commit = wrEn && wrByteEn[LANES-1];
  assign wipe   = busReset || ctl.clearAll;
  assign step   = ctl.stepTwo ? CNT_W'(2) : CNT_W'(beatBytes);

  always_comb begin
    mergedCnt = '0;
    for (int k = 0; k < LANES - 1; k++) begin
      mergedCnt[k*8 +: 8] = wrByteEn[k] ? wrData[k*8 +: 8] : staged[k];
    end
    mergedCnt[CNT_W-1 -: 8] = wrData[CNT_W-1 -: 8];
  end

  genvar g;
  generate
    for (g = 0; g < LANES - 1; g++) begin : gLane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          staged[g] <= '0;
        end else if (wipe) begin
          staged[g] <= '0;
        end else if (wrEn && wrByteEn[g]) begin
          staged[g] <= wrData[g*8 +: 8];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (wipe) begin
      cnt <= '0;
    end else if (commit) begin
      cnt <= mergedCnt;
    end else if (ctl.decEn) begin
      cnt <= (cnt > step) ? cnt - step : '0;
    end
  end

  assign cntIsZero = (cnt == '0);
  assign lastBeat  = (cnt <= step) && !commit;

  // R2: lower-lane writes alone keep the working count
  a_r2_low_lane_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrByteEn[LANES-1] && !ctl.decEn && !wipe) |=> $stable(cnt));

  // R5: decrement never wraps upward
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.decEn && !commit && !wipe) |=> (cnt <= $past(cnt)));

  // R8: unit reset clears count
  a_r8_clear_count: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (cnt == '0 && staged == '0));

endmodule

// File: rtl/dmaCountCtrl.sv
module dmaCountCtrl
  import dma_cnt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdCode,
  input  logic        cntDisable,
  input  logic        beatValid,
  input  logic        eotIn,
  input  logic        cntIsZero,
  input  logic        lastBeat,
  output pathCtl_t    ctl,
  output logic        busy,
  output logic        done,
  output logic        eotFlush
);
  logic      active;
  logic      dirIn;
  xferMode_e mode;
  logic      isStart, isReset, isStop;
  logic      ctrOff, newCtrOff;

  assign isStart   = cmdValid && (cmdCode <= CMD_LAST_START);
  assign isReset   = cmdValid && (cmdCode == CMD_UNIT_RESET);
  assign isStop    = cmdValid && (cmdCode == CMD_MDMA_STOP);
  assign ctrOff    = cntDisable && (mode == MODE_GDMA);
  assign newCtrOff = cntDisable && (cmdCode[2:1] == 2'(MODE_GDMA));

  always_comb begin
    ctl          = '0;
    ctl.clearAll = isReset;
    ctl.decEn    = active && beatValid && !ctrOff && !isReset;
    ctl.stepTwo  = (mode == MODE_PIO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      dirIn    <= 1'b0;
      mode     <= MODE_GDMA;
      done     <= 1'b0;
      eotFlush <= 1'b0;
    end else begin
      done     <= 1'b0;
      eotFlush <= 1'b0;
      if (isReset) begin
        active <= 1'b0;
        dirIn  <= 1'b0;
        mode   <= MODE_GDMA;
      end else if (active) begin
        if (ctl.decEn && lastBeat) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else if (ctrOff && dirIn && eotIn) begin
          active   <= 1'b0;
          done     <= 1'b1;
          eotFlush <= 1'b1;
        end
        if (isStop && mode == MODE_MDMA) begin
          active <= 1'b0;
        end
      end else if (isStart) begin
        if (cntIsZero && !newCtrOff) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1;
          mode   <= xferMode_e'(cmdCode[2:1]);
          dirIn  <= cmdCode[0];
        end
      end
    end
  end

  assign busy = active;

  // R5: completion pulse only when no longer busy
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: start while busy is ignored
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (active && isStart && !beatValid && !eotIn) |=> (active && mode == $past(mode)));

  // R8: unit reset returns to idle
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    isReset |=> (!active && !done));

  // R9: stop outside MDMA has no effect
  a_r9_stop_mdma_only: assert property (@(posedge clk) disable iff (!rstN)
    (isStop && active && mode != MODE_MDMA && !beatValid && !eotIn) |=> active);

  // R11: flush only together with done
  a_r11_flush_with_done: assert property (@(posedge clk) disable iff (!rstN)
    eotFlush |-> done);

endmodule

// File: rtl/dmaCountUnit.sv
module dmaCountUnit
  import dma_cnt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BEAT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               wrEn,
  input  logic [CNT_W/8-1:0] wrByteEn,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               cmdValid,
  input  logic [7:0]         cmdCode,
  input  logic               cntDisable,
  input  logic               beatValid,
  input  logic [BEAT_W-1:0]  beatBytes,
  input  logic               eotIn,
  output logic [CNT_W-1:0]   remainCnt,
  output logic               busy,
  output logic               done,
  output logic               eotFlush
);
  pathCtl_t ctl;
  logic     cntIsZero;
  logic     lastBeat;

  dmaCountCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cntDisable (cntDisable),
    .beatValid  (beatValid),
    .eotIn      (eotIn),
    .cntIsZero  (cntIsZero),
    .lastBeat   (lastBeat),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .eotFlush   (eotFlush)
  );

  dmaCountPath #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .busReset  (busReset),
    .wrEn      (wrEn),
    .wrByteEn  (wrByteEn),
    .wrData    (wrData),
    .beatBytes (beatBytes),
    .ctl       (ctl),
    .cnt       (remainCnt),
    .cntIsZero (cntIsZero),
    .lastBeat  (lastBeat)
  );

endmodule

// File: tb/tb_dmaCountUnit.sv
`timescale 1ns/100ps
module tb_dmaCountUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReset = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrByteEn = '0;
  logic [31:0] wrData = '0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdCode = '0;
  logic        cntDisable = 1'b0;
  logic        beatValid = 1'b0;
  logic [2:0]  beatBytes = '0;
  logic        eotIn = 1'b0;
  logic [31:0] remainCnt;
  logic        busy, done, eotFlush;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmaCountUnit dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkCnt(input string req, input logic [31:0] exp);
    check(remainCnt === exp, req, remainCnt, exp);
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    check(act === exp, req, 32'(act), 32'(exp));
  endtask

  task automatic wrReg(input logic [3:0] be, input logic [31:0] d);
    wrEn = 1'b1; wrByteEn = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0;
  endtask

  task automatic cmd(input logic [7:0] c);
    cmdValid = 1'b1; cmdCode = c;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic beat(input logic [2:0] n);
    beatValid = 1'b1; beatBytes = n;
    @(negedge clk);
    beatValid = 1'b0;
  endtask

  task automatic unitReset();
    cmd(8'h11);
    cntDisable = 1'b0;
  endtask

  task automatic testReset();
    chkCnt("R3 reset count", 32'h0);
    chkBit("R3 reset busy", busy, 1'b0);
    chkBit("R3 reset done", done, 1'b0);
  endtask

  task automatic testStaging();
    wrReg(4'b0001, 32'h0000_0010);
    wrReg(4'b0010, 32'h0000_2000);
    wrReg(4'b0100, 32'h0030_0000);
    chkCnt("R2 lower lanes hold", 32'h0);
    wrReg(4'b1000, 32'h4000_0000);
    chkCnt("R1 commit staged", 32'h4030_2010);
    wrReg(4'b0011, 32'h0000_0102);
    chkCnt("R2 word write hold", 32'h4030_2010);
    wrReg(4'b1000, 32'h0000_0000);
    chkCnt("R1 commit merged word", 32'h0030_0102);
    wrReg(4'b1111, 32'h0000_0010);
    chkCnt("R1 full write", 32'h10);
  endtask

  task automatic testGdmaCount();
    cmd(8'h00);
    chkBit("R4 start busy", busy, 1'b1);
    beat(3'd4); beat(3'd4); beat(3'd4);
    chkCnt("R5 decrement", 32'd4);
    chkBit("R5 still busy", busy, 1'b1);
    beat(3'd4);
    chkCnt("R5 reach zero", 32'd0);
    chkBit("R5 done pulse", done, 1'b1);
    chkBit("R5 busy drops", busy, 1'b0);
    @(negedge clk);
    chkBit("R5 done one cycle", done, 1'b0);
    wrReg(4'b1111, 32'd6);
    cmd(8'h03);
    beat(3'd4);
    chkCnt("R5 partial", 32'd2);
    beat(3'd4);
    chkCnt("R5 saturate no wrap", 32'd0);
    chkBit("R5 saturate done", done, 1'b1);
  endtask

  task automatic testPio();
    wrReg(4'b1111, 32'd6);
    cmd(8'h04);
    beat(3'd4);
    chkCnt("R6 pio step two", 32'd4);
    beat(3'd1);
    chkCnt("R6 pio ignores beatBytes", 32'd2);
    beat(3'd4);
    chkBit("R6 pio done", done, 1'b1);
    @(negedge clk);
  endtask

  task automatic testBusyStartStop();
    wrReg(4'b1111, 32'd8);
    cmd(8'h01);
    cmd(8'h06);
    chkBit("R7 start while busy keeps busy", busy, 1'b1);
    cmd(8'h12);
    chkBit("R9 stop ignored in generic", busy, 1'b1);
    beat(3'd2);
    chkCnt("R7 mode kept generic step", 32'd6);
    unitReset();
    @(negedge clk);
  endtask

  task automatic testMdmaStop();
    wrReg(4'b1111, 32'd12);
    cmd(8'h06);
    beat(3'd4);
    cmd(8'h12);
    chkBit("R9 mdma stop busy", busy, 1'b0);
    chkBit("R9 mdma stop no done", done, 1'b0);
    chkCnt("R9 count kept", 32'd8);
    cmd(8'h12);
    chkBit("R9 stop idle no effect", busy, 1'b0);
  endtask

  task automatic testReserved();
    wrReg(4'b1111, 32'd8);
    cmd(8'h07);
    cmd(8'h13); cmd(8'hFF); cmd(8'h08); cmd(8'h10);
    chkBit("R10 reserved busy", busy, 1'b1);
    chkCnt("R10 reserved count", 32'd8);
    chkBit("R10 reserved done", done, 1'b0);
    unitReset();
    @(negedge clk);
  endtask

  task automatic testUnitReset();
    wrReg(4'b0111, 32'h00AA_AAAA);
    wrReg(4'b1111, 32'd20);
    wrReg(4'b0111, 32'h00AA_AAAA);
    cmd(8'h02);
    cmd(8'h11);
    chkBit("R8 reset busy", busy, 1'b0);
    chkCnt("R8 reset count", 32'h0);
    wrReg(4'b1000, 32'h0100_0000);
    chkCnt("R8 staged cleared", 32'h0100_0000);
    wrReg(4'b0111, 32'h00BB_BBBB);
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
    chkCnt("R3 bus reset count", 32'h0);
    wrReg(4'b1000, 32'h0200_0000);
    chkCnt("R3 bus reset staged", 32'h0200_0000);
  endtask

  task automatic testZeroStart();
    wrReg(4'b1111, 32'h0);
    cmd(8'h02);
    chkBit("R7 zero start done", done, 1'b1);
    chkBit("R7 zero start idle", busy, 1'b0);
  endtask

  task automatic testCounterOff();
    wrReg(4'b1111, 32'd4);
    cntDisable = 1'b1;
    cmd(8'h01);
    beat(3'd4); beat(3'd4);
    chkCnt("R11 disabled no decrement", 32'd4);
    chkBit("R11 disabled busy", busy, 1'b1);
    eotIn = 1'b1;
    @(negedge clk);
    eotIn = 1'b0;
    chkBit("R11 eot done", done, 1'b1);
    chkBit("R11 eot flush", eotFlush, 1'b1);
    chkBit("R11 eot idle", busy, 1'b0);
    cmd(8'h02);
    beat(3'd4);
    chkBit("R11 udma ignores disable", done, 1'b1);
    chkCnt("R11 udma count", 32'd0);
    cntDisable = 1'b0;
  endtask

  task automatic testCommitVsBeat();
    wrReg(4'b1111, 32'd8);
    cmd(8'h00);
    wrEn = 1'b1; wrByteEn = 4'b1111; wrData = 32'h20;
    beatValid = 1'b1; beatBytes = 3'd4;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0; beatValid = 1'b0;
    chkCnt("R12 commit wins", 32'h20);
    chkBit("R12 still busy", busy, 1'b1);
    unitReset();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStaging();
    testGdmaCount();
    testPio();
    testBusyStartStop();
    testMdmaStop();
    testReserved();
    testUnitReset();
    testZeroStart();
    testCounterOff();
    testCommitVsBeat();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule